// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits beside the decode stage of a five-stage in-order pipeline. It spots the single case that result forwarding cannot cover: a load now in the execute stage whose destination register is read by the instruction now in decode. The loaded value only leaves memory one stage later, so the dependent instruction has to wait one cycle. The block does this by producing three control lines that act together. The first stops the program counter from advancing. The second holds the decode-stage instruction register. The third replaces the control word sent into execute with all zeros.

The detector itself is purely combinational and holds no state. When the load moves on, the bubble it inserted occupies execute, so the match clears by itself and the stall lasts exactly one cycle. An instruction that depends only on the stalled instruction, or on anything further down the pipe, gets no stall from this block. Those cases belong to forwarding.

The block is made of three parts. One comparator is generated per source field of the decode instruction. An OR stage merges the comparator hits into a stall decision. An output stage turns that decision into the three coordinated enables.

Top module: `hzd_load_use`

## Requirements
- R1: When `idex_mem_read` is 1 and `idex_dest` equals the first source field, instruction bits [25:21], a stall is signalled.
- R2: When `idex_mem_read` is 1 and `idex_dest` equals the second source field, instruction bits [20:16], a stall is signalled.
- R3: When `idex_mem_read` is 0, no stall is signalled, whatever the register fields hold.
- R4: When `idex_mem_read` is 1 and neither source field equals `idex_dest`, no stall is signalled.
- R5: `pc_we` is 0 during a stall and 1 otherwise.
- R6: `ifid_we` is 0 during a stall and 1 otherwise.
- R7: `ctrl_bubble` is 1 (control word forced to zero) during a stall and 0 (decoded control passes) otherwise.
- R8: Instruction bits [31:26] and [15:0] have no effect on any output.
- R9: The three outputs always agree: `pc_we` equals `ifid_we`, and `ctrl_bubble` is the inverse of `pc_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ifid_instr | input | 32 | Instruction word held in the fetch/decode pipeline register |
| idex_mem_read | input | 1 | Instruction in execute reads data memory (a load) |
| idex_dest | input | 5 | Register the execute-stage load will write |
| pc_we | output | 1 | 1 lets the program counter advance; 0 holds it |
| ifid_we | output | 1 | 1 loads the next instruction into the fetch/decode register; 0 holds it |
| ctrl_bubble | output | 1 | 1 forces the control word passed to execute to zero |

## Verification
Every combination of the load flag, the destination and both source fields is applied at the default 5-bit register width. This separates a match on the first field, a match on the second field, matches on both, and the case with no match, and each of these is tried with the load flag both set and clear. Each vector also carries pseudo-random opcode and immediate bits. A subset of vectors is repeated with those bits inverted, which shows that bits outside the two source fields cannot cause or suppress a stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Meaning of the bubble-select line toward the control mux of execute
    typedef enum logic {
        CTRL_PASS = 1'b0,
        CTRL_ZERO = 1'b1
    } ctrl_sel_e;

    // Stall decision carried between the merge stage and the output stage
    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HOLD = 1'b1
    } flow_e;

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int ADDR_W = 5
) (
    input  logic              load_pending,
    input  logic [ADDR_W-1:0] load_dest,
    input  logic [ADDR_W-1:0] src_reg,
    output logic              hit
);

    always_comb begin
        hit = load_pending && (load_dest == src_reg);
    end

endmodule

// File: rtl/hzd_flow_ctrl.sv
module hzd_flow_ctrl
    import hzd_pkg::*;
(
    input  flow_e flow,
    output logic  pc_we,
    output logic  ifid_we,
    output logic  ctrl_bubble
);

    ctrl_sel_e sel;

    always_comb begin
        unique case (flow)
            FLOW_HOLD: begin
                pc_we   = 1'b0;
                ifid_we = 1'b0;
                sel     = CTRL_ZERO;
            end
            default: begin
                pc_we   = 1'b1;
                ifid_we = 1'b1;
                sel     = CTRL_PASS;
            end
        endcase
        ctrl_bubble = sel;
    end

    // R5/R6/R7: stall holds fetch, holds decode, zeros control
    always_comb begin
        if (flow == FLOW_HOLD) begin
            assert_hold_freezes_R5: assert (pc_we == 1'b0);
            assert_hold_keeps_decode_R6: assert (ifid_we == 1'b0);
            assert_hold_bubbles_R7: assert (ctrl_bubble == 1'b1);
        end
    end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
    import hzd_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int ADDR_W   = 5,
    parameter int SRC_BASE = 16,
    parameter int NUM_SRC  = 2
) (
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic               idex_mem_read,
    input  logic [ADDR_W-1:0]  idex_dest,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ctrl_bubble
);

    // Source field i sits at SRC_BASE + i*ADDR_W (i=0: bits 20:16, i=1: bits 25:21)
    localparam int SRC_TOP = SRC_BASE + NUM_SRC * ADDR_W - 1;

    logic [NUM_SRC-1:0] src_hit;
    flow_e              flow;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int LSB = SRC_BASE + i * ADDR_W;
        hzd_src_cmp #(
            .ADDR_W(ADDR_W)
        ) i_cmp (
            .load_pending (idex_mem_read),
            .load_dest    (idex_dest),
            .src_reg      (ifid_instr[LSB +: ADDR_W]),
            .hit          (src_hit[i])
        );
    end

    always_comb begin
        flow = (|src_hit) ? FLOW_HOLD : FLOW_RUN;
    end

    hzd_flow_ctrl i_flow (
        .flow        (flow),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .ctrl_bubble (ctrl_bubble)
    );

    // Port-level checks next to the merge logic
    always_comb begin
        if (idex_mem_read && idex_dest == ifid_instr[SRC_BASE + ADDR_W +: ADDR_W]) begin
            assert_first_src_stall_R1: assert (ctrl_bubble == 1'b1);
        end
        if (idex_mem_read && idex_dest == ifid_instr[SRC_BASE +: ADDR_W]) begin
            assert_second_src_stall_R2: assert (ctrl_bubble == 1'b1);
        end
        if (!idex_mem_read) begin
            assert_no_load_no_stall_R3: assert (pc_we == 1'b1);
        end
        assert_outputs_agree_R9: assert (pc_we == ifid_we && ctrl_bubble == !pc_we);
        assert_field_range_R8: assert (SRC_TOP < INSTR_W);
    end

endmodule

// File: tb/test_hzd_load_use.sv
module test_hzd_load_use;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int NREG       = 1 << ADDR_W;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic        idex_mem_read = 1'b0;
    logic [4:0]  idex_dest = '0;
    logic        pc_we, ifid_we, ctrl_bubble;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    logic [31:0] lfsr = 32'hACE1_1234;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_load_use i_hzd_load_use (
        .ifid_instr    (ifid_instr),
        .idex_mem_read (idex_mem_read),
        .idex_dest     (idex_dest),
        .pc_we         (pc_we),
        .ifid_we       (ifid_we),
        .ctrl_bubble   (ctrl_bubble)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input logic stall);
        check(stall ? "R5" : req, pc_we, !stall, "pc_we");
        check(stall ? "R6" : req, ifid_we, !stall, "ifid_we");
        check(stall ? "R7" : req, ctrl_bubble, stall, "ctrl_bubble");
        check("R9", (pc_we == ifid_we) && (ctrl_bubble == !pc_we), 1'b1, "coherence");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Idle state: no load in execute
        @(negedge clk);
        #1;
        check_outputs("R3", 1'b0);

        for (int mr = 0; mr < 2; mr++) begin
            for (int d = 0; d < NREG; d++) begin
                for (int s1 = 0; s1 < NREG; s1++) begin
                    for (int s2 = 0; s2 < NREG; s2++) begin
                        logic  stall;
                        string tag;
                        @(negedge clk);
                        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                        idex_mem_read = mr[0];
                        idex_dest     = d[4:0];
                        ifid_instr    = {lfsr[31:26], s1[4:0], s2[4:0], lfsr[15:0]};
                        stall = (mr == 1) && (d == s1 || d == s2);
                        if (mr == 0)      tag = "R3";
                        else if (d == s1) tag = "R1";
                        else if (d == s2) tag = "R2";
                        else              tag = "R4";
                        #1;
                        check(tag, ctrl_bubble, stall, "stall decision");
                        check_outputs(tag, stall);
                        if (s2 == d || s2 == 0) begin
                            // R8: flip opcode and immediate bits, outputs must not move
                            ifid_instr[31:26] = ~ifid_instr[31:26];
                            ifid_instr[15:0]  = ~ifid_instr[15:0];
                            #1;
                            check("R8", ctrl_bubble, stall, "bubble with flipped bits");
                            check("R8", pc_we, !stall, "pc_we with flipped bits");
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule